// File: doc/BRIEF.md
# Reset Source Detection Unit

This block watches every source that can restart the processor and turns each one into a single-cycle reset request for the CPU exception sequencer. The request comes with a code that says whether a power-on reset or a manual reset must be taken. The block's two reset pins are asynchronous. Each pin is synchronised, and a request starts on its release edge, when the pin goes from low to high. A watchdog overflow pulse also starts a reset. A static select input decides whether that reset is power-on or manual. A debug port can start a power-on reset with a pair of commands. The reset starts only when a release command follows an earlier arm command.

A sticky cause register records which sources have fired since the last power-on reset that came from the pin. Software can read it after the restart to find why the processor restarted. A power-on reset from the pin clears the older history. Resets from any other source only add to it.

Top module: `rstsrc_top`

## Requirements
- R1: After the block's own reset `rst_n`, `rst_req_o` is 0, `rst_kind_o` is 2'b00 and `cause_o` is 0.
- R2: A low-to-high transition on `por_pin_i` produces exactly one request cycle with `rst_kind_o` = 2'b01 (power-on). The request is seen SYNC_STAGES+1 rising clock edges after the transition is set up. A low level or a falling transition on the pin produces no request.
- R3: A low-to-high transition on `mrst_pin_i` produces exactly one request cycle, with the same latency as R2, with `rst_kind_o` = 2'b10 (manual).
- R4: A `dbg_clr_i` pulse while an arm is pending (a `dbg_set_i` was seen since the last firing) gives a power-on request in the cycle after the pulse. Each arm gives at most one firing.
- R5: A `dbg_clr_i` pulse with no arm pending is ignored: no request and no cause change.
- R6: A `wdt_ovf_i` pulse gives a request in the next cycle. The request is power-on when `wdt_kind_i` is 0 and manual when it is 1.
- R7: When power-on and manual sources fire in the same cycle, the single request carries the power-on code 2'b01.
- R8: `cause_o` bits are sticky. Bit 0 is the power-on pin, bit 1 the manual pin, bit 2 the debug port and bit 3 the watchdog. Each bit is set in the same cycle as the request from its source.
- R9: A power-on pin event replaces `cause_o` with only the sources firing in that cycle. Debug, watchdog and manual resets never clear bits.
- R10: `rst_kind_o` is 2'b00 exactly when `rst_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset of the detection logic itself |
| por_pin_i | input | 1 | Asynchronous power-on reset pin, low = asserted |
| mrst_pin_i | input | 1 | Asynchronous manual reset pin, low = asserted |
| wdt_ovf_i | input | 1 | Single-cycle watchdog overflow pulse |
| wdt_kind_i | input | 1 | Watchdog reset type: 0 power-on, 1 manual |
| dbg_set_i | input | 1 | Debug reset arm command pulse |
| dbg_clr_i | input | 1 | Debug reset release command pulse |
| rst_req_o | output | 1 | Single-cycle reset request |
| rst_kind_o | output | 2 | 2'b01 power-on, 2'b10 manual, 2'b00 none |
| cause_o | output | 4 | Sticky reset cause bits |

## Verification
The hardest case to reach is a pin event that lines up in the same cycle with a watchdog or debug event. The pin passes through the synchroniser, so its internal edge appears several cycles after the port changes. The bench counts those register stages. It raises the pin, then injects a manual-type watchdog pulse exactly in the cycle where the synchronised edge is live. This checks both priority and the clearing of the cause register. A sweep over all combinations of the watchdog and debug command inputs, run with and without a pending arm, covers the command state machine.

// File: rtl/rstsrc_pkg.sv
package rstsrc_pkg;
    typedef enum logic [1:0] {
        RK_IDLE    = 2'b00,
        RK_POWERON = 2'b01,
        RK_MANUAL  = 2'b10
    } rst_kind_e;

    localparam int CAUSE_W    = 4;
    localparam int CB_POR_PIN = 0;
    localparam int CB_MAN_PIN = 1;
    localparam int CB_DEBUG   = 2;
    localparam int CB_WDT     = 3;

    typedef struct packed {
        logic               req;
        rst_kind_e          kind;
        logic [CAUSE_W-1:0] cause;
    } arb_state_t;
endpackage

// File: rtl/rstsrc_pin_edge.sv
module rstsrc_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    // Stages [STAGES-1:0] synchronise; the top stage holds the previous sample.
    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], pin_i};
    end

    // Reset to the released level so that a released pin does not look like an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/rstsrc_dbg_seq.sv
module rstsrc_dbg_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic fire_o,
    output logic armed_o
);
    logic armed_d, armed_q;

    always_comb begin
        fire_o  = clr_i & armed_q;
        armed_d = set_i | (armed_q & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

    assign armed_o = armed_q;
endmodule

// File: rtl/rstsrc_top.sv
module rstsrc_top
    import rstsrc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_pin_i,
    input  logic               mrst_pin_i,
    input  logic               wdt_ovf_i,
    input  logic               wdt_kind_i,
    input  logic               dbg_set_i,
    input  logic               dbg_clr_i,
    output logic               rst_req_o,
    output logic [1:0]         rst_kind_o,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam int NUM_PINS = 2;

    logic [NUM_PINS-1:0] pin_raw;
    logic [NUM_PINS-1:0] pin_rise;
    logic                pin_por_rise;
    logic                pin_man_rise;
    logic                dbg_fire;
    logic                dbg_armed;

    assign pin_raw = {mrst_pin_i, por_pin_i};

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        rstsrc_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_raw[g]),
            .rise_o (pin_rise[g])
        );
    end

    assign pin_por_rise = pin_rise[0];
    assign pin_man_rise = pin_rise[1];

    rstsrc_dbg_seq u_dbg (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (dbg_set_i),
        .clr_i   (dbg_clr_i),
        .fire_o  (dbg_fire),
        .armed_o (dbg_armed)
    );

    arb_state_t         st_d, st_q;
    logic               want_por;
    logic               want_man;
    logic [CAUSE_W-1:0] hits;

    always_comb begin
        want_por = pin_por_rise | dbg_fire | (wdt_ovf_i & ~wdt_kind_i);
        want_man = pin_man_rise | (wdt_ovf_i & wdt_kind_i);

        hits             = '0;
        hits[CB_POR_PIN] = pin_por_rise;
        hits[CB_MAN_PIN] = pin_man_rise;
        hits[CB_DEBUG]   = dbg_fire;
        hits[CB_WDT]     = wdt_ovf_i;

        st_d.req = want_por | want_man;
        if (want_por)      st_d.kind = RK_POWERON;
        else if (want_man) st_d.kind = RK_MANUAL;
        else               st_d.kind = RK_IDLE;

        // Only a pin power-on reset wipes the history.
        if (pin_por_rise) st_d.cause = hits;
        else              st_d.cause = st_q.cause | hits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{req: 1'b0, kind: RK_IDLE, cause: '0};
        else        st_q <= st_d;
    end

    assign rst_req_o  = st_q.req;
    assign rst_kind_o = st_q.kind;
    assign cause_o    = st_q.cause;
endmodule

// File: rtl/rstsrc_chk.sv
module rstsrc_chk
    import rstsrc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wdt_ovf_i,
    input logic               wdt_kind_i,
    input logic               dbg_clr_i,
    input logic               dbg_armed,
    input logic               pin_por_rise,
    input logic               pin_man_rise,
    input logic               rst_req_o,
    input logic [1:0]         rst_kind_o,
    input logic [CAUSE_W-1:0] cause_o
);
    // R10: code and request agree
    assert_kind_matches_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o == (rst_kind_o != 2'b00));

    // R6: watchdog selects the type
    assert_wdt_poweron_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_ovf_i && !wdt_kind_i) |=> (rst_req_o && rst_kind_o == 2'b01));

    assert_wdt_manual_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_ovf_i && wdt_kind_i && !pin_por_rise && !(dbg_clr_i && dbg_armed))
        |=> (rst_req_o && rst_kind_o == 2'b10));

    // R4: release after arm fires a power-on request
    assert_dbg_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_clr_i && dbg_armed) |=> (rst_req_o && rst_kind_o == 2'b01));

    // R5: release without arm does nothing
    assert_dbg_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_clr_i && !dbg_armed && !wdt_ovf_i && !pin_por_rise && !pin_man_rise)
        |=> !rst_req_o);

    // R7: power-on wins
    assert_poweron_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_por_rise && pin_man_rise) |=> (rst_kind_o == 2'b01));

    // R9: without a pin power-on event no cause bit is lost
    assert_cause_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_por_rise |=> ((cause_o & $past(cause_o)) == $past(cause_o)));
endmodule

bind rstsrc_top rstsrc_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wdt_ovf_i    (wdt_ovf_i),
    .wdt_kind_i   (wdt_kind_i),
    .dbg_clr_i    (dbg_clr_i),
    .dbg_armed    (dbg_armed),
    .pin_por_rise (pin_por_rise),
    .pin_man_rise (pin_man_rise),
    .rst_req_o    (rst_req_o),
    .rst_kind_o   (rst_kind_o),
    .cause_o      (cause_o)
);

// File: tb/rstsrc_top_tb_top.sv
module rstsrc_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_pin_i = 1'b1;
    logic       mrst_pin_i = 1'b1;
    logic       wdt_ovf_i = 1'b0;
    logic       wdt_kind_i = 1'b0;
    logic       dbg_set_i = 1'b0;
    logic       dbg_clr_i = 1'b0;
    logic       rst_req_o;
    logic [1:0] rst_kind_o;
    logic [3:0] cause_o;

    int tests = 0;
    int fails = 0;
    logic [3:0] exp_cause = 4'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstsrc_top #(.SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n), .por_pin_i(por_pin_i), .mrst_pin_i(mrst_pin_i),
        .wdt_ovf_i(wdt_ovf_i), .wdt_kind_i(wdt_kind_i), .dbg_set_i(dbg_set_i),
        .dbg_clr_i(dbg_clr_i), .rst_req_o(rst_req_o), .rst_kind_o(rst_kind_o),
        .cause_o(cause_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input logic req, input logic [1:0] kind);
        chk(rst_req_o === req, {tag, " req"}, int'(rst_req_o), int'(req));
        chk(rst_kind_o === kind, {tag, " kind"}, int'(rst_kind_o), int'(kind));
        chk(cause_o === exp_cause, {tag, " cause R8"}, int'(cause_o), int'(exp_cause));
    endtask

    // Release one pin after holding it low; request expected SYNC+1 negedges later.
    task automatic pin_event(input bit man, input string tag);
        int seen = 0;
        int at = -1;
        @(negedge clk);
        if (man) mrst_pin_i = 1'b0; else por_pin_i = 1'b0;
        for (int i = 0; i < SYNC + 3; i++) begin
            @(negedge clk);
            chk(rst_req_o === 1'b0, {tag, " low/falling R2"}, int'(rst_req_o), 0);
        end
        if (man) mrst_pin_i = 1'b1; else por_pin_i = 1'b1;
        for (int i = 1; i <= SYNC + 4; i++) begin
            @(negedge clk);
            if (rst_req_o === 1'b1) begin
                seen++;
                at = i;
                chk(rst_kind_o === (man ? 2'b10 : 2'b01), {tag, " kind"},
                    int'(rst_kind_o), man ? 2 : 1);
            end
        end
        chk(seen == 1, {tag, " single pulse"}, seen, 1);
        chk(at == SYNC + 1, {tag, " latency"}, at, SYNC + 1);
        if (man) exp_cause |= 4'b0010; else exp_cause = 4'b0001;
        chk(cause_o === exp_cause, {tag, " cause R9"}, int'(cause_o), int'(exp_cause));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_out("R1 reset", 1'b0, 2'b00);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk_out("R1 after release", 1'b0, 2'b00);

        pin_event(1'b1, "R3 manual pin");
        pin_event(1'b0, "R2 poweron pin");
        pin_event(1'b1, "R3 manual pin again");

        // Sweep watchdog/debug commands with and without a pending arm (R4 R5 R6 R8)
        for (int a = 0; a < 2; a++) begin
            for (int v = 0; v < 16; v++) begin
                bit ovf, knd, st, cl, fire, arm_after, e_req;
                logic [1:0] e_kind;
                ovf = v[3]; knd = v[2]; st = v[1]; cl = v[0];
                if (a == 1) begin
                    dbg_set_i = 1'b1;
                    @(negedge clk);
                    dbg_set_i = 1'b0;
                    chk_out("R4 arm alone", 1'b0, 2'b00);
                end
                wdt_ovf_i = ovf; wdt_kind_i = knd; dbg_set_i = st; dbg_clr_i = cl;
                fire   = cl && (a == 1);
                e_req  = fire || ovf;
                e_kind = (fire || (ovf && !knd)) ? 2'b01 : (ovf ? 2'b10 : 2'b00);
                if (fire) exp_cause[2] = 1'b1;
                if (ovf)  exp_cause[3] = 1'b1;
                @(negedge clk);
                wdt_ovf_i = 1'b0; wdt_kind_i = 1'b0; dbg_set_i = 1'b0; dbg_clr_i = 1'b0;
                chk_out(fire ? "R4 sweep" : (cl ? "R5 sweep" : "R6 sweep"), e_req, e_kind);
                arm_after = st || ((a == 1) && !cl);
                if (arm_after) begin
                    dbg_clr_i = 1'b1;
                    exp_cause[2] = 1'b1;
                    @(negedge clk);
                    dbg_clr_i = 1'b0;
                    chk_out("R4 drain", 1'b1, 2'b01);
                end
                @(negedge clk);
                chk_out("R10 idle", 1'b0, 2'b00);
                dbg_clr_i = 1'b1;
                @(negedge clk);
                dbg_clr_i = 1'b0;
                chk_out("R5 one firing per arm", 1'b0, 2'b00);
            end
        end

        // Both pins together: power-on wins and cause holds both (R7 R9)
        @(negedge clk);
        por_pin_i = 1'b0; mrst_pin_i = 1'b0;
        repeat (SYNC + 3) @(negedge clk);
        por_pin_i = 1'b1; mrst_pin_i = 1'b1;
        repeat (SYNC + 1) @(negedge clk);
        exp_cause = 4'b0011;
        chk_out("R7 both pins", 1'b1, 2'b01);

        // Pin edge coincides with manual watchdog (R7 R9)
        @(negedge clk);
        por_pin_i = 1'b0;
        repeat (SYNC + 3) @(negedge clk);
        por_pin_i = 1'b1;
        repeat (SYNC) @(negedge clk);
        chk(rst_req_o === 1'b0, "R2 before edge", int'(rst_req_o), 0);
        wdt_ovf_i = 1'b1; wdt_kind_i = 1'b1;
        @(negedge clk);
        wdt_ovf_i = 1'b0; wdt_kind_i = 1'b0;
        exp_cause = 4'b1001;
        chk_out("R7 R9 pin with wdt", 1'b1, 2'b01);
        @(negedge clk);
        chk_out("R10 after", 1'b0, 2'b00);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule